// File: doc/BRIEF.md
# Protected System-Register Access Guard

This block decides, in a single combinational pass, what happens when software reads or writes a protected configuration-mask register through either its primary name or its alternate alias name. It looks at the requester's privilege level (0 to 3), the access direction, which name was used, and the state of the higher levels' controls. These controls cover feature presence, the level-3 gate and its debug-undefined variants, the level-2 enable and host mode, an extended-control gate, fine-grained read and write permits, and the 3-bit nested-virtualisation control.

Exactly one verdict leaves the block. The verdict is one of: undefined instruction, trap to level 2, trap to level 3, redirect to a memory page at a fixed offset, or a plain access to the level-1 or level-2 copy of the register. Every trap carries a fixed syndrome class. A redirect carries its page offset. The register storage sits outside the block. The surrounding pipeline feeds it the "copy is nonzero" flags, which turn some writes into undefined accesses.

All pins are plain control and status signals. No data stream crosses the block, so there is no valid/ready handshake. The outputs follow the inputs combinationally.

Top module: `sysreg_guard`

## Requirements
- R1: If the masking feature or the 64-bit state feature is absent, every access through either name is undefined.
- R2: Any access from privilege level 0 is undefined, through either name.
- R3: At level 1 with the primary name, when level 3 exists, the debug-undefined-first flag is 1 and the level-3 gate is 0, the access is undefined. This check takes priority over every later check.
- R4: At level 1 with the primary name, when level 2 is enabled and the fine-grained feature is present, the access traps to level 2 in two cases: level 3 exists and its fine-grained enable is 0, or the permit for this direction is 0. Reads use the read permit and writes use the write permit.
- R5: At level 1 with the primary name, if the R4 trap does not apply, an enabled level 2 whose extended-control gate is unavailable or 0 causes a trap to level 2.
- R6: At level 1 with the primary name, if none of the above applies and level 3 exists with its gate at 0, the access is undefined when the debug-undefined flag is 1. Otherwise it traps to level 3.
- R7: At level 1 with the primary name, if none of the above applies, a nested-virtualisation control of 3'b111 redirects to memory. Otherwise a write while the level-1 copy is nonzero is undefined. Every other access reaches the level-1 copy.
- R8: At level 2 with the primary name, the R3 check and then the R6 check apply. After them, host mode selects the level-2 copy, and a write while the level-2 copy is nonzero is undefined. Outside host mode, the access reaches the level-1 copy. At level 3, the primary name always reaches the level-1 copy.
- R9: At level 1 with the alias name, a control of 3'b101 redirects to memory. Otherwise, when control bit 0 is 1 the access traps to level 2. In all other cases the access is undefined.
- R10: At levels 2 and 3 with the alias name, the access is undefined outside host mode. In host mode, level 2 first applies the R3 and R6 checks and then reaches the level-1 copy. Level 3 in host mode always reaches the level-1 copy.
- R11: The syndrome output is 0x18 for either trap and 0 otherwise. The offset output is 0x328 for a redirect and 0 otherwise.
- R12: Exactly one of the six verdict outputs is 1 for every input combination.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| priv_lvl | input | 2 | Privilege level of the requester |
| wr_req | input | 1 | 1 = write, 0 = read |
| alias_sel | input | 1 | 1 = alias name used |
| has_mask_feat | input | 1 | Masking feature present |
| has_a64 | input | 1 | 64-bit state feature present |
| has_l3 | input | 1 | Level 3 implemented |
| l3_gate_en | input | 1 | Level-3 enable for this register |
| l3_fg_en | input | 1 | Level-3 enable for fine-grained traps |
| dbg_undef_first | input | 1 | Debug-undefined takes priority |
| dbg_undef | input | 1 | Debug-undefined in force |
| l2_enabled | input | 1 | Level 2 enabled |
| has_fg2 | input | 1 | Second fine-grained trap feature present |
| host_mode | input | 1 | Level 2 runs in host mode |
| xctl_avail | input | 1 | Extended-control register available |
| xctl_gate_en | input | 1 | Extended-control enable for this register |
| fg_rd_allow | input | 1 | Fine-grained read permit (0 traps) |
| fg_wr_allow | input | 1 | Fine-grained write permit (0 traps) |
| nv_ctl | input | 3 | Nested-virtualisation control |
| l1_mask_nz | input | 1 | Level-1 copy is nonzero |
| l2_mask_nz | input | 1 | Level-2 copy is nonzero |
| res_undef | output | 1 | Verdict: undefined |
| res_trap_l2 | output | 1 | Verdict: trap to level 2 |
| res_trap_l3 | output | 1 | Verdict: trap to level 3 |
| res_mem | output | 1 | Verdict: redirect to memory |
| res_l1_copy | output | 1 | Verdict: access level-1 copy |
| res_l2_copy | output | 1 | Verdict: access level-2 copy |
| syn_class | output | 6 | Syndrome class on a trap |
| mem_off | output | 12 | Page offset on a redirect |

## Verification
The priority chain is tested with one permissive configuration. Each test clears a single control, or a pair of controls, so that the verdict shows which rung fired first. For example, a cleared read permit traps a read but leaves a write alone. A redirect control of 3'b111 still yields to an extended-control trap. Level-2 accesses ignore the level-1-only traps. All eight nested-virtualisation values are swept for both names at level 1, which separates the 3'b101 redirect, the bit-0 trap and the undefined fallback. A pseudo-random sweep over every input then checks that the verdict is one-hot and that the syndrome and offset agree with it.

// File: rtl/sgd_pkg.sv
package sgd_pkg;
  typedef enum logic [2:0] {
    VD_UNDEF = 3'd0,
    VD_TRAP2 = 3'd1,
    VD_TRAP3 = 3'd2,
    VD_MEM   = 3'd3,
    VD_ACC1  = 3'd4,
    VD_ACC2  = 3'd5
  } verdict_e;

  localparam int unsigned NUM_VERDICTS = 6;

  // Result of the level-3 gating rungs
  typedef struct packed {
    logic early_undef;  // priority debug-undefined rung
    logic late_block;   // gate closed, takes late verdict
    logic late_undef;   // 1: late verdict is undefined, 0: trap to level 3
  } l3_gate_t;
endpackage

// File: rtl/sgd_l3_gate.sv
module sgd_l3_gate
  import sgd_pkg::*;
(
  input  logic     has_l3,
  input  logic     gate_en,
  input  logic     undef_first,
  input  logic     undef_now,
  output l3_gate_t gate
);
  logic closed;
  always_comb begin
    closed           = has_l3 && !gate_en;
    gate.early_undef = closed && undef_first;
    gate.late_block  = closed;
    gate.late_undef  = undef_now;
  end
endmodule

// File: rtl/sgd_primary.sv
module sgd_primary
  import sgd_pkg::*;
#(
  parameter int unsigned NV_W    = 3,
  parameter logic [NV_W-1:0] NV_REDIR = 3'b111
) (
  input  logic [1:0]      lvl,
  input  logic            wr,
  input  l3_gate_t        gate,
  input  logic            has_l3,
  input  logic            l3_fg_en,
  input  logic            l2_enabled,
  input  logic            has_fg2,
  input  logic            host_mode,
  input  logic            xctl_avail,
  input  logic            xctl_gate_en,
  input  logic            fg_rd_allow,
  input  logic            fg_wr_allow,
  input  logic [NV_W-1:0] nv_ctl,
  input  logic            l1_nz,
  input  logic            l2_nz,
  output verdict_e        verdict
);
  logic fg_permit;
  logic fg_trap;
  logic xctl_trap;
  logic late_verdict_undef;

  always_comb begin
    fg_permit = wr ? fg_wr_allow : fg_rd_allow;
    fg_trap   = l2_enabled && has_fg2 && ((has_l3 && !l3_fg_en) || !fg_permit);
    xctl_trap = l2_enabled && (!xctl_avail || !xctl_gate_en);
    late_verdict_undef = gate.late_undef;
  end

  always_comb begin
    verdict = VD_UNDEF;
    unique case (lvl)
      2'd0: verdict = VD_UNDEF;
      2'd1: begin
        if (gate.early_undef)      verdict = VD_UNDEF;
        else if (fg_trap)          verdict = VD_TRAP2;
        else if (xctl_trap)        verdict = VD_TRAP2;
        else if (gate.late_block)  verdict = late_verdict_undef ? VD_UNDEF : VD_TRAP3;
        else if (nv_ctl == NV_REDIR) verdict = VD_MEM;
        else if (wr && l1_nz)      verdict = VD_UNDEF;
        else                       verdict = VD_ACC1;
      end
      2'd2: begin
        if (gate.early_undef)      verdict = VD_UNDEF;
        else if (gate.late_block)  verdict = late_verdict_undef ? VD_UNDEF : VD_TRAP3;
        else if (host_mode)        verdict = (wr && l2_nz) ? VD_UNDEF : VD_ACC2;
        else                       verdict = VD_ACC1;
      end
      default: verdict = VD_ACC1;
    endcase
  end

  // Level 1 traps never reach a level-2 requester
  always_comb begin
    if (lvl == 2'd2)
      assert (verdict != VD_TRAP2) else $error("assert_l2_no_l2trap_R8");
  end
endmodule

// File: rtl/sgd_alias.sv
module sgd_alias
  import sgd_pkg::*;
#(
  parameter int unsigned NV_W    = 3,
  parameter logic [NV_W-1:0] NV_REDIR = 3'b101
) (
  input  logic [1:0]      lvl,
  input  l3_gate_t        gate,
  input  logic            host_mode,
  input  logic [NV_W-1:0] nv_ctl,
  output verdict_e        verdict
);
  always_comb begin
    verdict = VD_UNDEF;
    unique case (lvl)
      2'd0: verdict = VD_UNDEF;
      2'd1: begin
        if (nv_ctl == NV_REDIR) verdict = VD_MEM;
        else if (nv_ctl[0])     verdict = VD_TRAP2;
        else                    verdict = VD_UNDEF;
      end
      2'd2: begin
        if (!host_mode)            verdict = VD_UNDEF;
        else if (gate.early_undef) verdict = VD_UNDEF;
        else if (gate.late_block)  verdict = gate.late_undef ? VD_UNDEF : VD_TRAP3;
        else                       verdict = VD_ACC1;
      end
      default: verdict = host_mode ? VD_ACC1 : VD_UNDEF;
    endcase
  end

  always_comb begin
    if (lvl >= 2'd2 && !host_mode)
      assert (verdict == VD_UNDEF) else $error("assert_alias_nohost_undef_R10");
  end
endmodule

// File: rtl/sgd_encode.sv
module sgd_encode
  import sgd_pkg::*;
#(
  parameter int unsigned SYN_W      = 6,
  parameter logic [SYN_W-1:0] TRAP_CLASS = 6'h18,
  parameter int unsigned OFF_W      = 12,
  parameter logic [OFF_W-1:0] MEM_OFFSET = 12'h328
) (
  input  verdict_e               verdict,
  output logic [NUM_VERDICTS-1:0] onehot,
  output logic [SYN_W-1:0]        syn_class,
  output logic [OFF_W-1:0]        mem_off
);
  for (genvar gi = 0; gi < NUM_VERDICTS; gi++) begin : g_dec
    assign onehot[gi] = (verdict == verdict_e'(3'(gi)));
  end

  always_comb begin
    syn_class = (verdict == VD_TRAP2 || verdict == VD_TRAP3) ? TRAP_CLASS : '0;
    mem_off   = (verdict == VD_MEM) ? MEM_OFFSET : '0;
  end
endmodule

// File: rtl/sysreg_guard.sv
module sysreg_guard
  import sgd_pkg::*;
#(
  parameter int unsigned SYN_W       = 6,
  parameter logic [SYN_W-1:0] TRAP_CLASS = 6'h18,
  parameter int unsigned OFF_W       = 12,
  parameter logic [OFF_W-1:0] MEM_OFFSET = 12'h328,
  parameter int unsigned NV_W        = 3,
  parameter logic [NV_W-1:0] NV_PRIMARY_REDIR = 3'b111,
  parameter logic [NV_W-1:0] NV_ALIAS_REDIR   = 3'b101
) (
  input  logic [1:0]       priv_lvl,
  input  logic             wr_req,
  input  logic             alias_sel,
  input  logic             has_mask_feat,
  input  logic             has_a64,
  input  logic             has_l3,
  input  logic             l3_gate_en,
  input  logic             l3_fg_en,
  input  logic             dbg_undef_first,
  input  logic             dbg_undef,
  input  logic             l2_enabled,
  input  logic             has_fg2,
  input  logic             host_mode,
  input  logic             xctl_avail,
  input  logic             xctl_gate_en,
  input  logic             fg_rd_allow,
  input  logic             fg_wr_allow,
  input  logic [NV_W-1:0]  nv_ctl,
  input  logic             l1_mask_nz,
  input  logic             l2_mask_nz,
  output logic             res_undef,
  output logic             res_trap_l2,
  output logic             res_trap_l3,
  output logic             res_mem,
  output logic             res_l1_copy,
  output logic             res_l2_copy,
  output logic [SYN_W-1:0] syn_class,
  output logic [OFF_W-1:0] mem_off
);
  l3_gate_t gate;
  verdict_e v_primary;
  verdict_e v_alias;
  verdict_e v_final;
  logic [NUM_VERDICTS-1:0] onehot;
  logic present;

  sgd_l3_gate u_gate (
    .has_l3      (has_l3),
    .gate_en     (l3_gate_en),
    .undef_first (dbg_undef_first),
    .undef_now   (dbg_undef),
    .gate        (gate)
  );

  sgd_primary #(.NV_W(NV_W), .NV_REDIR(NV_PRIMARY_REDIR)) u_primary (
    .lvl          (priv_lvl),
    .wr           (wr_req),
    .gate         (gate),
    .has_l3       (has_l3),
    .l3_fg_en     (l3_fg_en),
    .l2_enabled   (l2_enabled),
    .has_fg2      (has_fg2),
    .host_mode    (host_mode),
    .xctl_avail   (xctl_avail),
    .xctl_gate_en (xctl_gate_en),
    .fg_rd_allow  (fg_rd_allow),
    .fg_wr_allow  (fg_wr_allow),
    .nv_ctl       (nv_ctl),
    .l1_nz        (l1_mask_nz),
    .l2_nz        (l2_mask_nz),
    .verdict      (v_primary)
  );

  sgd_alias #(.NV_W(NV_W), .NV_REDIR(NV_ALIAS_REDIR)) u_alias (
    .lvl       (priv_lvl),
    .gate      (gate),
    .host_mode (host_mode),
    .nv_ctl    (nv_ctl),
    .verdict   (v_alias)
  );

  always_comb begin
    present = has_mask_feat && has_a64;
    if (!present)       v_final = VD_UNDEF;
    else if (alias_sel) v_final = v_alias;
    else                v_final = v_primary;
  end

  sgd_encode #(
    .SYN_W(SYN_W), .TRAP_CLASS(TRAP_CLASS), .OFF_W(OFF_W), .MEM_OFFSET(MEM_OFFSET)
  ) u_encode (
    .verdict   (v_final),
    .onehot    (onehot),
    .syn_class (syn_class),
    .mem_off   (mem_off)
  );

  assign res_undef   = onehot[VD_UNDEF];
  assign res_trap_l2 = onehot[VD_TRAP2];
  assign res_trap_l3 = onehot[VD_TRAP3];
  assign res_mem     = onehot[VD_MEM];
  assign res_l1_copy = onehot[VD_ACC1];
  assign res_l2_copy = onehot[VD_ACC2];

  always_comb begin
    assert ($countones({res_undef, res_trap_l2, res_trap_l3, res_mem, res_l1_copy, res_l2_copy}) == 1)
      else $error("assert_single_verdict_R12");
    assert ((mem_off != '0) == res_mem) else $error("assert_offset_only_redirect_R11");
    assert ((syn_class != '0) == (res_trap_l2 || res_trap_l3)) else $error("assert_syndrome_only_trap_R11");
    if (!has_mask_feat || !has_a64)
      assert (res_undef) else $error("assert_absent_undef_R1");
    if (priv_lvl == 2'd0)
      assert (res_undef) else $error("assert_lvl0_undef_R2");
  end
endmodule

// File: tb/sysreg_guard_bench.sv
module sysreg_guard_bench;
  localparam time CLK_PERIOD = 10ns;

  // flag bit positions of the stimulus word
  localparam int F_FEATM = 0, F_A64 = 1, F_HAS3 = 2, F_L3EN = 3, F_L3FG = 4,
                 F_PRIO = 5, F_DBG = 6, F_L2EN = 7, F_FG2 = 8, F_HOST = 9,
                 F_XAV = 10, F_XEN = 11, F_FGRD = 12, F_FGWR = 13, F_L1NZ = 14, F_L2NZ = 15;
  localparam logic [15:0] M_FEATM = 16'h1 << F_FEATM, M_A64 = 16'h1 << F_A64,
    M_HAS3 = 16'h1 << F_HAS3, M_L3EN = 16'h1 << F_L3EN, M_L3FG = 16'h1 << F_L3FG,
    M_PRIO = 16'h1 << F_PRIO, M_DBG = 16'h1 << F_DBG, M_L2EN = 16'h1 << F_L2EN,
    M_FG2 = 16'h1 << F_FG2, M_HOST = 16'h1 << F_HOST, M_XAV = 16'h1 << F_XAV,
    M_XEN = 16'h1 << F_XEN, M_FGRD = 16'h1 << F_FGRD, M_FGWR = 16'h1 << F_FGWR,
    M_L1NZ = 16'h1 << F_L1NZ, M_L2NZ = 16'h1 << F_L2NZ;
  localparam logic [15:0] BASE = 16'h3D9F;  // every gate open, nothing nonzero

  // verdict codes {l2copy,l1copy,mem,trap3,trap2,undef}
  localparam logic [5:0] O_UND = 6'b000001, O_T2 = 6'b000010, O_T3 = 6'b000100,
                         O_MEM = 6'b001000, O_A1 = 6'b010000, O_A2 = 6'b100000;

  localparam int NV = 43;
  function automatic logic [32:0] mk(input logic [3:0] req, input logic [1:0] lvl,
      input logic wr, input logic als, input logic [2:0] nv, input logic [15:0] fl,
      input logic [5:0] ex);
    return {req, lvl, wr, als, nv, fl, ex};
  endfunction

  localparam logic [32:0] VECS [NV] = '{
    mk(4'd7, 2'd1, 1'b0, 1'b0, 3'd0, BASE, O_A1),                      // R7 read plain
    mk(4'd7, 2'd1, 1'b1, 1'b0, 3'd0, BASE, O_A1),                      // R7 write plain
    mk(4'd7, 2'd1, 1'b1, 1'b0, 3'd0, BASE | M_L1NZ, O_UND),            // R7 write nonzero
    mk(4'd1, 2'd1, 1'b0, 1'b0, 3'd0, BASE & ~M_FEATM, O_UND),          // R1
    mk(4'd1, 2'd3, 1'b0, 1'b1, 3'd0, (BASE | M_HOST) & ~M_A64, O_UND), // R1 alias
    mk(4'd2, 2'd0, 1'b0, 1'b0, 3'd0, BASE, O_UND),                     // R2
    mk(4'd3, 2'd1, 1'b0, 1'b0, 3'd0, (BASE | M_PRIO) & ~(M_L3EN | M_FGRD), O_UND), // R3 beats R4
    mk(4'd4, 2'd1, 1'b0, 1'b0, 3'd0, BASE & ~M_FGRD, O_T2),            // R4 read permit
    mk(4'd4, 2'd1, 1'b1, 1'b0, 3'd0, BASE & ~M_FGRD, O_A1),            // R4 write ignores read permit
    mk(4'd4, 2'd1, 1'b1, 1'b0, 3'd0, BASE & ~M_FGWR, O_T2),            // R4 write permit
    mk(4'd4, 2'd1, 1'b0, 1'b0, 3'd0, BASE & ~M_L3FG, O_T2),            // R4 level-3 fg enable
    mk(4'd4, 2'd1, 1'b0, 1'b0, 3'd0, BASE & ~(M_L3FG | M_HAS3), O_A1), // R4 no level 3
    mk(4'd4, 2'd1, 1'b0, 1'b0, 3'd0, BASE & ~(M_FG2 | M_FGRD), O_A1),  // R4 feature absent
    mk(4'd5, 2'd1, 1'b0, 1'b0, 3'd0, BASE & ~M_XEN, O_T2),             // R5
    mk(4'd5, 2'd1, 1'b0, 1'b0, 3'd0, BASE & ~M_XAV, O_T2),             // R5
    mk(4'd5, 2'd1, 1'b0, 1'b0, 3'd0, BASE & ~(M_L2EN | M_XEN), O_A1),  // R5 level 2 off
    mk(4'd6, 2'd1, 1'b0, 1'b0, 3'd0, BASE & ~M_L3EN, O_T3),            // R6
    mk(4'd6, 2'd1, 1'b0, 1'b0, 3'd0, (BASE | M_DBG) & ~M_L3EN, O_UND), // R6 debug
    mk(4'd6, 2'd1, 1'b0, 1'b0, 3'd0, BASE & ~(M_L3EN | M_HAS3), O_A1), // R6 no level 3
    mk(4'd7, 2'd1, 1'b0, 1'b0, 3'd7, BASE, O_MEM),                     // R7 redirect
    mk(4'd7, 2'd1, 1'b0, 1'b0, 3'd5, BASE, O_A1),                      // R7 alias code on primary
    mk(4'd7, 2'd1, 1'b1, 1'b0, 3'd7, BASE | M_L1NZ, O_MEM),            // R7 redirect before nonzero
    mk(4'd5, 2'd1, 1'b0, 1'b0, 3'd7, BASE & ~M_XEN, O_T2),             // R5 before redirect
    mk(4'd8, 2'd2, 1'b0, 1'b0, 3'd0, BASE, O_A1),                      // R8
    mk(4'd8, 2'd2, 1'b0, 1'b0, 3'd0, BASE | M_HOST, O_A2),             // R8 host
    mk(4'd8, 2'd2, 1'b1, 1'b0, 3'd0, BASE | M_HOST | M_L2NZ, O_UND),   // R8 host write nonzero
    mk(4'd8, 2'd2, 1'b1, 1'b0, 3'd0, BASE | M_L1NZ, O_A1),             // R8 nonhost write
    mk(4'd8, 2'd2, 1'b0, 1'b0, 3'd0, BASE & ~M_L3EN, O_T3),            // R8 gate
    mk(4'd8, 2'd2, 1'b0, 1'b0, 3'd0, (BASE | M_PRIO) & ~M_L3EN, O_UND),// R8 priority undef
    mk(4'd8, 2'd2, 1'b0, 1'b0, 3'd7, BASE & ~(M_FGRD | M_XEN), O_A1),  // R8 level-1 rungs skipped
    mk(4'd8, 2'd3, 1'b1, 1'b0, 3'd0, (BASE | M_L1NZ) & ~M_L3EN, O_A1), // R8 level 3
    mk(4'd9, 2'd1, 1'b0, 1'b1, 3'd5, BASE, O_MEM),                     // R9
    mk(4'd9, 2'd1, 1'b0, 1'b1, 3'd7, BASE, O_T2),                      // R9
    mk(4'd9, 2'd1, 1'b1, 1'b1, 3'd1, BASE, O_T2),                      // R9
    mk(4'd9, 2'd1, 1'b0, 1'b1, 3'd0, BASE, O_UND),                     // R9
    mk(4'd9, 2'd1, 1'b0, 1'b1, 3'd4, BASE, O_UND),                     // R9
    mk(4'd10, 2'd2, 1'b0, 1'b1, 3'd0, BASE, O_UND),                    // R10 nonhost
    mk(4'd10, 2'd2, 1'b1, 1'b1, 3'd0, BASE | M_HOST | M_L1NZ, O_A1),   // R10 host
    mk(4'd10, 2'd2, 1'b0, 1'b1, 3'd0, (BASE | M_HOST) & ~M_L3EN, O_T3),// R10 gate
    mk(4'd10, 2'd2, 1'b0, 1'b1, 3'd0, (BASE | M_HOST | M_DBG) & ~M_L3EN, O_UND), // R10
    mk(4'd10, 2'd3, 1'b0, 1'b1, 3'd0, (BASE | M_HOST) & ~M_L3EN, O_A1),// R10 level 3
    mk(4'd10, 2'd3, 1'b0, 1'b1, 3'd0, BASE, O_UND),                    // R10 level 3 nonhost
    mk(4'd2, 2'd0, 1'b0, 1'b1, 3'd5, BASE | M_HOST, O_UND)             // R2 alias
  };

  logic clk = 1'b0;
  always #(CLK_PERIOD / 2) clk = ~clk;

  logic [1:0] priv_lvl;
  logic wr_req, alias_sel;
  logic [15:0] fl;
  logic [2:0] nv_ctl;
  logic res_undef, res_trap_l2, res_trap_l3, res_mem, res_l1_copy, res_l2_copy;
  logic [5:0] syn_class;
  logic [11:0] mem_off;
  int n_checks = 0, n_fail = 0;
  bit done = 0;

  sysreg_guard u_sysreg_guard (
    .priv_lvl(priv_lvl), .wr_req(wr_req), .alias_sel(alias_sel),
    .has_mask_feat(fl[F_FEATM]), .has_a64(fl[F_A64]), .has_l3(fl[F_HAS3]),
    .l3_gate_en(fl[F_L3EN]), .l3_fg_en(fl[F_L3FG]), .dbg_undef_first(fl[F_PRIO]),
    .dbg_undef(fl[F_DBG]), .l2_enabled(fl[F_L2EN]), .has_fg2(fl[F_FG2]),
    .host_mode(fl[F_HOST]), .xctl_avail(fl[F_XAV]), .xctl_gate_en(fl[F_XEN]),
    .fg_rd_allow(fl[F_FGRD]), .fg_wr_allow(fl[F_FGWR]), .nv_ctl(nv_ctl),
    .l1_mask_nz(fl[F_L1NZ]), .l2_mask_nz(fl[F_L2NZ]),
    .res_undef(res_undef), .res_trap_l2(res_trap_l2), .res_trap_l3(res_trap_l3),
    .res_mem(res_mem), .res_l1_copy(res_l1_copy), .res_l2_copy(res_l2_copy),
    .syn_class(syn_class), .mem_off(mem_off)
  );

  function automatic logic [5:0] got();
    return {res_l2_copy, res_l1_copy, res_mem, res_trap_l3, res_trap_l2, res_undef};
  endfunction

  task automatic drive(input logic [1:0] l, input logic w, input logic a,
                       input logic [2:0] n, input logic [15:0] f);
    @(posedge clk);
    priv_lvl = l; wr_req = w; alias_sel = a; nv_ctl = n; fl = f;
    @(negedge clk);
  endtask

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  // R11 side outputs follow the verdict; R12 one-hot
  task automatic check_side(input string req);
    logic [5:0] g;
    g = got();
    check($countones(g) == 1, "R12 one verdict", int'(g), 1);
    check(syn_class == ((res_trap_l2 || res_trap_l3) ? 6'h18 : 6'h0), {req, " R11 syndrome"},
          int'(syn_class), (res_trap_l2 || res_trap_l3) ? 'h18 : 0);
    check(mem_off == (res_mem ? 12'h328 : 12'h0), {req, " R11 offset"},
          int'(mem_off), res_mem ? 'h328 : 0);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    priv_lvl = '0; wr_req = 0; alias_sel = 0; nv_ctl = '0; fl = '0;
    // Rest state: everything zero, features absent (R1)
    @(negedge clk);
    check(got() == O_UND, "R1 idle inputs", int'(got()), int'(O_UND));
    check_side("R1 idle");

    // Table walk
    for (int i = 0; i < NV; i++) begin
      logic [32:0] v;
      v = VECS[i];
      drive(v[28:27], v[26], v[25], v[24:22], v[21:6]);
      check(got() == v[5:0], $sformatf("R%0d vector %0d", v[32:29], i), int'(got()), int'(v[5:0]));
      check_side($sformatf("R%0d vector %0d", v[32:29], i));
    end

    // R9 sweep of the alias name at level 1 over all control codes
    for (int n = 0; n < 8; n++) begin
      logic [5:0] e;
      e = (n == 5) ? O_MEM : (n[0] ? O_T2 : O_UND);
      drive(2'd1, 1'b0, 1'b1, 3'(n), BASE);
      check(got() == e, $sformatf("R9 alias nv=%0d", n), int'(got()), int'(e));
    end
    // R7 sweep of the primary name at level 1 over all control codes
    for (int n = 0; n < 8; n++) begin
      logic [5:0] e;
      e = (n == 7) ? O_MEM : O_A1;
      drive(2'd1, 1'b1, 1'b0, 3'(n), BASE);
      check(got() == e, $sformatf("R7 primary nv=%0d", n), int'(got()), int'(e));
    end
    // R12 and R11 over pseudo-random inputs
    for (int k = 0; k < 300; k++) begin
      logic [31:0] r;
      r = $urandom;
      drive(r[1:0], r[2], r[3], r[6:4], r[22:7]);
      check_side("R12 sweep");
    end

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule